// File: doc/BRIEF.md
# Selectable Data Address Pointer Bank

This block keeps a bank of 24-bit data address pointers for a small processor core and presents one of them, the active pointer, to the address path. Software reaches the active pointer through three byte lanes (low, high, extended). A step command moves the active pointer by one, up or down according to a direction bit that each pointer owns. A second strobe, raised after qualifying data-move operations, steps the active pointer as well, but only when that pointer has automatic stepping enabled.

A select register picks the active pointer. Its low bit is the only bit that an increment of the register changes; the bit above it is not implemented, and a separate pair bit (bit 2) chooses between pointers 0/1 and 2/3. An increment therefore swaps partners inside a pair and never crosses pairs. A control register holds the direction and auto-step enable bits. All state sits behind a plain register write/read port with a combinational read.

Top module: `ptr_bank_top`

## Requirements
- R1: After reset every pointer, the select register, all direction bits and all auto-step enables are zero.
- R2: Writing address 0, 1 or 2 replaces the low (bits 7:0), high (bits 15:8) or extended (bits 23:16) byte of the active pointer only, and reading those addresses returns that byte of the active pointer.
- R3: With the active pointer's direction bit at 0, a step adds one modulo 2^24, so FFFFFFh becomes 000000h.
- R4: With the active pointer's direction bit at 1, a step subtracts one modulo 2^24, so 000000h becomes FFFFFFh.
- R5: The automatic step strobe steps the active pointer only when that pointer's auto-step enable (control bit 4 + pointer index) is 1; otherwise it has no effect.
- R6: A select increment inverts select bit 0 and leaves the pair bit (bit 2) unchanged, so it swaps pointer 0 with 1 and pointer 2 with 3; the active index is {bit 2, bit 0}.
- R7: Address 3 reads the select register with bit 0 and bit 2 as stored and all other bits zero; a write stores only data bits 0 and 2.
- R8: A byte write to the active pointer in the same cycle as a step applies the byte write and skips the step.
- R9: A step changes only the active pointer; the other pointers keep their values.
- R10: A step command and an enabled automatic step in the same cycle step the pointer once.
- R11: A write to the select register in the same cycle as a select increment stores the written value.
- R12: Address 4 reads and writes the control register, direction bits in bits 3:0 and auto-step enables in bits 7:4, indexed by pointer; addresses 5 to 7 read zero and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Register write address |
| wr_data | input | BYTE_W (8) | Register write data |
| rd_addr | input | ADDR_W (3) | Register read address |
| rd_data | output | BYTE_W (8) | Combinational read data |
| step_cmd | input | 1 | Step the active pointer by one |
| auto_step | input | 1 | Step after a qualifying data move, gated by the pointer's enable |
| sel_inc | input | 1 | Increment the select register |
| active_ptr | output | 24 | Value of the active pointer |
| active_idx | output | IDX_W (2) | Index of the active pointer |

## Verification
A wrong pointer value shows on active_ptr and on the byte lanes in the cycle right after the faulty edge, while a fault in an inactive pointer stays hidden until the select register points at it, so the bench revisits every pointer after each step series. A select fault shows at once on active_idx and on address 3. Wrap and carry faults only appear at specific values, so starting points such as 000000h, 0000FFh, 00FF00h and FFFFFFh are stepped in both directions on every pointer.

// File: rtl/ptr_bank_pkg.sv
package ptr_bank_pkg;
   // Register map of the bank's write/read port
   localparam int ADDR_W       = 3;
   localparam int SEL_LO_BIT   = 0;
   localparam int SEL_PAIR_BIT = 2;

   typedef enum logic [ADDR_W-1:0] {
      RA_LANE0 = 3'd0,
      RA_LANE1 = 3'd1,
      RA_LANE2 = 3'd2,
      RA_SEL   = 3'd3,
      RA_CTL   = 3'd4
   } reg_addr_e;
endpackage

// File: rtl/ptr_cell.sv
module ptr_cell #(
   parameter int BYTE_W    = 8,
   parameter int PTR_BYTES = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [PTR_BYTES-1:0]          lane_we,
   input  logic [BYTE_W-1:0]             wdata,
   input  logic                          step,
   input  logic                          down,
   output logic [BYTE_W*PTR_BYTES-1:0]   value
);
   localparam int PTR_W = BYTE_W * PTR_BYTES;
   localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

   logic [PTR_W-1:0] nxt;

   always_comb begin
      nxt = value;
      if (|lane_we) begin
         for (int i = 0; i < PTR_BYTES; i++) begin
            if (lane_we[i]) nxt[i*BYTE_W +: BYTE_W] = wdata;
         end
      end else if (step) begin
         nxt = down ? (value - ONE) : (value + ONE);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) value <= '0;
      else        value <= nxt;
   end

   // R3 R4
   step_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && lane_we == '0) |=>
         (value == ($past(down) ? $past(value) - ONE : $past(value) + ONE)));

   // R8
   write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane_we[0] |=> (value[BYTE_W-1:0] == $past(wdata)));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && lane_we == '0) |=> $stable(value));
endmodule

// File: rtl/ptr_sel_reg.sv
module ptr_sel_reg
   import ptr_bank_pkg::*;
#(
   parameter int NUM_PTRS = 4,
   parameter int BYTE_W   = 8,
   localparam int IDX_W   = $clog2(NUM_PTRS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              inc,
   output logic [IDX_W-1:0]  idx,
   output logic [BYTE_W-1:0] rd_val
);
   logic lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lo_q <= 1'b0;
      else if (wr)  lo_q <= wdata[SEL_LO_BIT];
      else if (inc) lo_q <= ~lo_q;
   end

   generate
      if (NUM_PTRS == 4) begin : g_pair
         logic pair_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  pair_q <= 1'b0;
            else if (wr) pair_q <= wdata[SEL_PAIR_BIT];
         end
         always_comb begin
            idx = {pair_q, lo_q};
            rd_val = '0;
            rd_val[SEL_LO_BIT]   = lo_q;
            rd_val[SEL_PAIR_BIT] = pair_q;
         end
         // R6
         inc_pair_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (inc && !wr) |=> (idx[1] == $past(idx[1])));
      end else begin : g_single
         always_comb begin
            idx = lo_q;
            rd_val = '0;
            rd_val[SEL_LO_BIT] = lo_q;
         end
      end
   endgenerate

   // R6
   inc_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !wr) |=> (idx[0] != $past(idx[0])));

   // R11
   wr_over_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (idx[0] == $past(wdata[SEL_LO_BIT])));
endmodule

// File: rtl/ptr_ctl_reg.sv
module ptr_ctl_reg #(
   parameter int NUM_PTRS = 4,
   parameter int BYTE_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic [BYTE_W-1:0]   wdata,
   output logic [NUM_PTRS-1:0] down_vec,
   output logic [NUM_PTRS-1:0] auto_vec,
   output logic [BYTE_W-1:0]   rd_val
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         down_vec <= '0;
         auto_vec <= '0;
      end else if (wr) begin
         down_vec <= wdata[NUM_PTRS-1:0];
         auto_vec <= wdata[2*NUM_PTRS-1:NUM_PTRS];
      end
   end

   always_comb begin
      rd_val = '0;
      rd_val[2*NUM_PTRS-1:0] = {auto_vec, down_vec};
   end

   // R12
   ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> ($stable(down_vec) && $stable(auto_vec)));
endmodule

// File: rtl/ptr_bank_top.sv
module ptr_bank_top
   import ptr_bank_pkg::*;
#(
   parameter int NUM_PTRS  = 4,
   parameter int BYTE_W    = 8,
   parameter int PTR_BYTES = 3,
   localparam int PTR_W    = BYTE_W * PTR_BYTES,
   localparam int IDX_W    = $clog2(NUM_PTRS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [BYTE_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [BYTE_W-1:0]  rd_data,
   input  logic               step_cmd,
   input  logic               auto_step,
   input  logic               sel_inc,
   output logic [PTR_W-1:0]   active_ptr,
   output logic [IDX_W-1:0]   active_idx
);
   generate
      if (!(NUM_PTRS == 2 || NUM_PTRS == 4)) begin : g_bad_count
         $error("ptr_bank_top: NUM_PTRS must be 2 or 4");
      end
      if (PTR_BYTES != 3) begin : g_bad_lanes
         $error("ptr_bank_top: register map assumes three byte lanes");
      end
      if (BYTE_W < 2 * NUM_PTRS) begin : g_bad_width
         $error("ptr_bank_top: control register needs 2*NUM_PTRS bits");
      end
   endgenerate

   logic                sel_wr, ctl_wr;
   logic [BYTE_W-1:0]   sel_rd, ctl_rd;
   logic [NUM_PTRS-1:0] down_vec, auto_vec;
   logic [PTR_BYTES-1:0] lane_hit;
   logic                step_fire;
   logic [PTR_W-1:0]    ptr_val [NUM_PTRS];
   logic [NUM_PTRS-1:0] cell_step;

   always_comb begin
      for (int l = 0; l < PTR_BYTES; l++)
         lane_hit[l] = wr_en && (wr_addr == ADDR_W'(l));
   end
   assign sel_wr = wr_en && (wr_addr == RA_SEL);
   assign ctl_wr = wr_en && (wr_addr == RA_CTL);

   ptr_sel_reg #(.NUM_PTRS(NUM_PTRS), .BYTE_W(BYTE_W)) u_sel (
      .clk(clk), .rst_n(rst_n), .wr(sel_wr), .wdata(wr_data),
      .inc(sel_inc), .idx(active_idx), .rd_val(sel_rd));

   ptr_ctl_reg #(.NUM_PTRS(NUM_PTRS), .BYTE_W(BYTE_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(wr_data),
      .down_vec(down_vec), .auto_vec(auto_vec), .rd_val(ctl_rd));

   assign step_fire = step_cmd || (auto_step && auto_vec[active_idx]);

   generate
      for (genvar p = 0; p < NUM_PTRS; p++) begin : g_ptr
         logic hit;
         assign hit = (active_idx == IDX_W'(p));
         assign cell_step[p] = hit && step_fire;
         ptr_cell #(.BYTE_W(BYTE_W), .PTR_BYTES(PTR_BYTES)) u_cell (
            .clk(clk), .rst_n(rst_n),
            .lane_we(hit ? lane_hit : '0),
            .wdata(wr_data),
            .step(cell_step[p]),
            .down(down_vec[p]),
            .value(ptr_val[p]));
      end
   endgenerate

   assign active_ptr = ptr_val[active_idx];

   always_comb begin
      rd_data = '0;
      if (rd_addr == RA_SEL)      rd_data = sel_rd;
      else if (rd_addr == RA_CTL) rd_data = ctl_rd;
      else begin
         for (int l = 0; l < PTR_BYTES; l++)
            if (rd_addr == ADDR_W'(l)) rd_data = active_ptr[l*BYTE_W +: BYTE_W];
      end
   end

   // R9
   one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cell_step));

   // R5
   auto_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_step && !step_cmd && !auto_vec[active_idx] && !wr_en && !sel_inc)
         |=> $stable(active_ptr));

   // R10
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_cmd && auto_step && !wr_en && !sel_inc && !down_vec[active_idx])
         |=> (active_ptr == $past(active_ptr) + PTR_W'(1)));
endmodule

// File: tb/ptr_bank_top_tb.sv
module ptr_bank_top_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 0, rst_n = 0;
   logic        wr_en = 0, step_cmd = 0, auto_step = 0, sel_inc = 0;
   logic [2:0]  wr_addr = 0, rd_addr = 0;
   logic [7:0]  wr_data = 0, rd_data;
   logic [23:0] active_ptr;
   logic [1:0]  active_idx;

   ptr_bank_top u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .step_cmd(step_cmd), .auto_step(auto_step), .sel_inc(sel_inc),
      .active_ptr(active_ptr), .active_idx(active_idx));

   always #(CLK_PERIOD/2) clk = ~clk;

   // expected-state model
   logic [23:0] m [4];
   logic [3:0]  mdir = 0, maen = 0;
   logic        msel0 = 0, msel2 = 0;
   int total = 0, bad = 0;

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      logic [1:0] ix;
      logic [7:0] e;
      ix = {msel2, msel0};
      for (int a = 0; a < 8; a++) begin
         rd_addr = 3'(a);
         #1;
         case (a)
            0, 1, 2: e = m[ix][a*8 +: 8];
            3:       e = {5'b0, msel2, 1'b0, msel0};
            4:       e = {maen, mdir};
            default: e = 8'h00;
         endcase
         chk(tag, $sformatf("addr%0d", a), 32'(rd_data), 32'(e));
      end
      chk(tag, "active_ptr", 32'(active_ptr), 32'(m[ix]));
      chk(tag, "active_idx", 32'(active_idx), 32'(ix));
   endtask

   task automatic tick(logic we, logic [2:0] a, logic [7:0] d,
                       logic st, logic au, logic inc);
      logic [1:0] ix;
      logic [23:0] nm;
      logic stepf;
      @(negedge clk);
      wr_en = we; wr_addr = a; wr_data = d;
      step_cmd = st; auto_step = au; sel_inc = inc;
      ix = {msel2, msel0};
      stepf = st | (au & maen[ix]);
      nm = m[ix];
      if (we && a < 3) nm[a*8 +: 8] = d;
      else if (stepf) nm = mdir[ix] ? nm - 24'd1 : nm + 24'd1;
      @(posedge clk);
      m[ix] = nm;
      if (we && a == 3) begin msel0 = d[0]; msel2 = d[2]; end
      else if (inc) msel0 = ~msel0;
      if (we && a == 4) {maen, mdir} = d;
      #1;
      wr_en = 0; step_cmd = 0; auto_step = 0; sel_inc = 0;
   endtask

   task automatic select(int p);
      tick(1, 3'd3, {5'b0, p[1], 1'b0, p[0]}, 0, 0, 0);
   endtask

   task automatic load(logic [23:0] v);
      tick(1, 3'd0, v[7:0], 0, 0, 0);
      tick(1, 3'd1, v[15:8], 0, 0, 0);
      tick(1, 3'd2, v[23:16], 0, 0, 0);
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [23:0] starts [6];
      starts = '{24'h000000, 24'hFFFFFF, 24'hFFFFFE, 24'h0000FF, 24'h00FF00, 24'h000100};
      for (int i = 0; i < 4; i++) m[i] = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      check_all("R1");
      for (int p = 0; p < 4; p++) begin
         select(p);
         check_all("R1");
      end

      // R2: byte lanes per pointer
      for (int p = 0; p < 4; p++) begin
         select(p);
         for (int l = 0; l < 3; l++) begin
            tick(1, 3'(l), 8'(p * 64 + l * 17 + 5), 0, 0, 0);
            check_all("R2");
         end
      end

      // R3 / R4 / R9: stepping sweep over every pointer and both directions
      for (int dn = 0; dn < 2; dn++) begin
         tick(1, 3'd4, dn ? 8'h0F : 8'h00, 0, 0, 0);
         check_all("R12");
         for (int p = 0; p < 4; p++) begin
            select(p);
            for (int s = 0; s < 6; s++) begin
               load(starts[s]);
               tick(0, 0, 0, 1, 0, 0);
               check_all(dn ? "R4" : "R3");
               tick(0, 0, 0, 1, 0, 0);
               check_all(dn ? "R4" : "R3");
            end
            for (int q = 0; q < 4; q++) begin
               select(q);
               check_all("R9");
            end
         end
      end

      // R5: auto strobe gated by enable
      tick(1, 3'd4, 8'h00, 0, 0, 0);
      for (int p = 0; p < 4; p++) begin
         select(p);
         tick(0, 0, 0, 0, 1, 0);
         check_all("R5");
      end
      tick(1, 3'd4, 8'h52, 0, 0, 0);
      check_all("R12");
      for (int p = 0; p < 4; p++) begin
         select(p);
         tick(0, 0, 0, 0, 1, 0);
         check_all("R5");
         tick(0, 0, 0, 1, 1, 0);
         check_all("R10");
      end

      // R6: select increments
      for (int p = 0; p < 4; p++) begin
         select(p);
         tick(0, 0, 0, 0, 0, 1);
         check_all("R6");
         tick(0, 0, 0, 0, 0, 1);
         check_all("R6");
      end

      // R7: only bits 0 and 2 stored
      tick(1, 3'd3, 8'hFF, 0, 0, 0);
      check_all("R7");
      tick(1, 3'd3, 8'hFA, 0, 0, 0);
      check_all("R7");

      // R8: byte write beats a step on the same pointer
      tick(1, 3'd4, 8'h00, 0, 0, 0);
      select(1);
      load(24'h12FFFF);
      tick(1, 3'd0, 8'h44, 1, 0, 0);
      check_all("R8");
      tick(1, 3'd2, 8'hA0, 1, 1, 0);
      check_all("R8");

      // R11: select write beats increment
      tick(1, 3'd3, 8'h04, 0, 0, 1);
      check_all("R11");
      tick(1, 3'd3, 8'h01, 0, 0, 1);
      check_all("R11");

      // R12: unused addresses
      for (int a = 5; a < 8; a++) begin
         tick(1, 3'(a), 8'hFF, 0, 0, 0);
         check_all("R12");
      end

      finish_run();
   end
endmodule